// File: doc/BRIEF.md
# Loadable Up-Counting Interrupt Timer

This block is an interrupt timer for a cartridge-side CPU bus. The CPU loads an 8-bit start value with a write to one register address and sets or clears a count-enable flag with a write to a second address. While the flag is set, the counter advances by one on each tick from the selected source. It raises an active-low interrupt while it holds the all-ones value. A further tick wraps it to zero, and it keeps counting from there.

There are three tick sources. The first is every CPU M2 cycle. The second is M2 divided by sixteen through a free-running prescaler. The third is each rising edge of a PPU address line, which is brought into the system clock domain by a two-stage synchronizer. All loads are synchronous to the system clock, so loads work in every mode. A write to the load register restarts the prescaler, so a load is never lost against a prescaled tick. To silence the timer, software loads $FF and clears the enable flag. The counter then stays parked.

The bus side uses plain single-cycle strobes: one `bus_we` pulse per CPU write and one `m2_pulse` per M2 cycle. Every write is accepted in the cycle it appears, so there is no back-pressure and no valid/ready handshake.

Top module: `irq_up_timer`

## Requirements
- R1: After reset the count is $00, the enable flag is 0, the prescaler phase is 0 and `irq_n` is 1.
- R2: A write (`bus_we`=1) with `bus_addr`=$E000 loads `bus_data` into the counter on that clock edge. It takes priority over a tick in the same cycle.
- R3: A write to $E001 sets the enable flag to `bus_data` bit 0, and bits 7..1 are ignored. A write to any other address changes neither the count nor the flag.
- R4: The count advances by exactly one per tick while the flag is 1, and holds while the flag is 0.
- R5: `irq_n` is 0 exactly while the flag is 1 and the count is $FF. A load of any other value, or clearing the flag, releases it at the next edge.
- R6: A tick at count $FF wraps the count to $00, which releases `irq_n`, and counting goes on from there.
- R7: With `src_sel`=0, every cycle with `m2_pulse`=1 is a tick.
- R8: With `src_sel`=1, a tick occurs on every sixteenth `m2_pulse`. A write to $E000 restarts this sequence, so the sixteenth pulse after the load is the first tick.
- R9: With `src_sel`=2, each rising edge of `ppu_line` is one tick once it has passed the two-stage synchronizer. A falling edge, a held level and `m2_pulse` produce no tick.
- R10: With `src_sel`=3, no tick is ever produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | One-cycle CPU write strobe |
| bus_addr | input | 16 | CPU address of the write |
| bus_data | input | 8 | CPU write data |
| m2_pulse | input | 1 | One-cycle pulse per CPU M2 cycle |
| ppu_line | input | 1 | Asynchronous PPU address line |
| src_sel | input | 2 | Tick source: 0 M2, 1 M2/16, 2 PPU edge, 3 off |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bound checker watches the following on every cycle:
- the load register takes the written byte, with priority over a tick;
- the count advances by one per enabled tick and holds while disabled;
- the count wraps from $FF to $00;
- the interrupt is released after a reload of a non-$FF value or after the flag is cleared;
- the tick is gated per source: M2 and divided modes tick only on M2 pulses, and the off mode never ticks.

Some properties span many cycles or depend on timing outside the block. These are shown only by the bench's directed and random sequences:
- the exact sixteen-pulse spacing of the divided mode, including its restart on a load;
- the synchronizer's single tick per rising PPU edge;
- that falling edges and held levels are ignored;
- the reset value, which is observed by counting 255 ticks up to the interrupt.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  typedef enum logic [1:0] {
    SRC_M2   = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_EDGE = 2'd2,
    SRC_OFF  = 2'd3
  } tick_src_e;
endpackage

// File: rtl/irqt_prescale.sv
// Free-running divider of the M2 pulse train, restarted by a load write.
module irqt_prescale #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic m2_pulse,
  output logic div_tick
);
  generate
    if (PRE_W == 0) begin : g_bypass
      assign div_tick = m2_pulse;
    end else begin : g_div
      localparam logic [PRE_W-1:0] LAST = '1;
      logic [PRE_W-1:0] phase;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          phase <= '0;
        end else if (restart) begin
          phase <= '0;
        end else if (m2_pulse) begin
          phase <= phase + 1'b1;
        end
      end

      assign div_tick = m2_pulse && (phase == LAST) && !restart;
    end
  endgenerate
endmodule

// File: rtl/irqt_edge_sync.sv
// Synchronizes an asynchronous line and flags each rising edge for one cycle.
module irqt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      sh <= {sh[SH_W-2:0], line_in};
    end
  end

  assign rise = sh[STAGES-1] && !sh[STAGES];
endmodule

// File: rtl/irqt_counter.sv
// Loadable wrapping up-counter with enable flag and terminal-count request.
module irqt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             enable,
  output logic             at_term
);
  localparam logic [CNT_W-1:0] TERM = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (enable && tick) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
    end else if (en_wr) begin
      enable <= en_val;
    end
  end

  assign at_term = enable && (count == TERM);
endmodule

// File: rtl/irq_up_timer.sv
module irq_up_timer #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              PRE_W     = 4,
  parameter int              SYNC_N    = 2,
  parameter logic [15:0]     LOAD_ADDR = 16'hE000,
  parameter logic [15:0]     ENA_ADDR  = 16'hE001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              m2_pulse,
  input  logic              ppu_line,
  input  logic [1:0]        src_sel,
  output logic              irq_n
);
  import irqt_pkg::*;

  localparam logic [ADDR_W-1:0] LD_A = LOAD_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] EN_A = ENA_ADDR[ADDR_W-1:0];

  logic              ld_hit;
  logic              en_hit;
  logic              div_tick;
  logic              edge_tick;
  logic              tick;
  logic [DATA_W-1:0] count;
  logic              enable;
  logic              at_term;
  tick_src_e         src;

  assign ld_hit = bus_we && (bus_addr == LD_A);
  assign en_hit = bus_we && (bus_addr == EN_A);
  assign src    = tick_src_e'(src_sel);

  irqt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ld_hit),
    .m2_pulse (m2_pulse),
    .div_tick (div_tick)
  );

  irqt_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (ppu_line),
    .rise    (edge_tick)
  );

  always_comb begin
    unique case (src)
      SRC_M2:   tick = m2_pulse;
      SRC_DIV:  tick = div_tick;
      SRC_EDGE: tick = edge_tick;
      default:  tick = 1'b0;
    endcase
  end

  irqt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_hit),
    .load_val (bus_data),
    .en_wr    (en_hit),
    .en_val   (bus_data[0]),
    .tick     (tick),
    .count    (count),
    .enable   (enable),
    .at_term  (at_term)
  );

  assign irq_n = !at_term;
endmodule

// File: rtl/irq_up_timer_chk.sv
module irq_up_timer_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] LOAD_ADDR = 16'hE000,
  parameter logic [15:0] ENA_ADDR  = 16'hE001
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              m2_pulse,
  input logic [1:0]        src_sel,
  input logic              irq_n,
  input logic              tick,
  input logic [DATA_W-1:0] count,
  input logic              enable
);
  logic ld_w, en_w;
  assign ld_w = bus_we && (bus_addr == LOAD_ADDR[ADDR_W-1:0]);
  assign en_w = bus_we && (bus_addr == ENA_ADDR[ADDR_W-1:0]);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_w |=> count == $past(bus_data));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_w && !enable) |=> $stable(count));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_w && enable && tick) |=> count == $past(count) + 1'b1);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_w && enable && tick && count == '1) |=> (count == '0 && irq_n));

  assert_release_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_w && bus_data != '1) |=> irq_n);

  assert_release_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && !bus_data[0]) |=> irq_n);

  assert_m2_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd0 && !m2_pulse) |-> !tick);

  assert_div_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd1 && tick) |-> m2_pulse);

  assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |-> !tick);
endmodule

bind irq_up_timer irq_up_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOAD_ADDR(LOAD_ADDR), .ENA_ADDR(ENA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_data(bus_data), .m2_pulse(m2_pulse), .src_sel(src_sel),
  .irq_n(irq_n), .tick(tick), .count(count), .enable(enable)
);

// File: tb/sim_irq_up_timer.sv
module sim_irq_up_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        m2_pulse = 1'b0;
  logic        ppu_line = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic        irq_n;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // bench reference state, derived from the requirements
  int m_cnt = 0;
  bit m_en = 1'b0;
  int m_pre = 0;

  always #5 clk = ~clk;

  irq_up_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_data(bus_data), .m2_pulse(m2_pulse), .ppu_line(ppu_line),
    .src_sel(src_sel), .irq_n(irq_n)
  );

  function automatic bit exp_irq_n();
    return !(m_en && m_cnt == 255);
  endfunction

  function automatic void model_tick();
    if (m_en) m_cnt = (m_cnt + 1) % 256;
  endfunction

  task automatic check_irq(string req);
    checks++;
    if (irq_n !== exp_irq_n()) begin
      fails++;
      $display("FAIL %s irq_n actual=%0b expected=%0b (cnt=%0d en=%0b)",
               req, irq_n, exp_irq_n(), m_cnt, m_en);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit with_m2);
    bus_we = 1'b1; bus_addr = a; bus_data = d; m2_pulse = with_m2;
    @(negedge clk);
    bus_we = 1'b0; m2_pulse = 1'b0;
    if (a == 16'hE000) begin
      m_cnt = d; m_pre = 0;                    // R2, R8: load wins, prescaler restarts
    end else begin
      if (with_m2) begin
        if (src_sel == 2'd0) model_tick();
        else if (src_sel == 2'd1 && m_pre == 15) model_tick();
        m_pre = (m_pre + 1) % 16;
      end
      if (a == 16'hE001) m_en = d[0];          // R3
    end
  endtask

  task automatic m2_one();
    m2_pulse = 1'b1;
    @(negedge clk);
    m2_pulse = 1'b0;
    if (src_sel == 2'd0) model_tick();         // R7
    else if (src_sel == 2'd1 && m_pre == 15) model_tick();  // R8
    m_pre = (m_pre + 1) % 16;
  endtask

  task automatic ppu_one();
    ppu_line = 1'b1;
    repeat (4) @(negedge clk);
    if (src_sel == 2'd2) model_tick();         // R9: one tick per rising edge
    ppu_line = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_src(input logic [1:0] s);
    src_sel = s;
    @(negedge clk);
  endtask

  initial begin : watchdog
    while (!finished && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check_irq("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_irq("R1 after reset");

    // R1/R4/R5: reset count 0, enable, 255 M2 ticks reach $FF
    bus_write(16'hE001, 8'h01, 0);
    for (int i = 0; i < 254; i++) m2_one();
    check_irq("R1 count 254 ticks from reset");
    m2_one();
    check_irq("R5 irq at $FF");
    m2_one();
    check_irq("R6 wrap releases irq");
    for (int i = 0; i < 254; i++) m2_one();
    m2_one();
    check_irq("R6 counting continues after wrap");

    // R5: clearing enable releases, park with $FF and flag 0
    bus_write(16'hE001, 8'hFE, 0);
    check_irq("R3 bit0 only clears enable, R5 release");
    bus_write(16'hE000, 8'hFF, 0);
    for (int i = 0; i < 20; i++) m2_one();
    check_irq("R4 parked, no count while disabled");
    bus_write(16'hE001, 8'h01, 0);
    check_irq("R5 re-enable at $FF asserts");
    bus_write(16'hE000, 8'h10, 0);
    check_irq("R5 reload releases");

    // R3: writes elsewhere ignored
    bus_write(16'hE000, 8'hFE, 0);
    bus_write(16'hE002, 8'hFF, 0);
    bus_write(16'hC000, 8'h00, 0);
    check_irq("R3 foreign writes ignored");
    m2_one();
    check_irq("R3 enable still set after foreign write");

    // R2: load priority over simultaneous tick
    bus_write(16'hE000, 8'hFF, 1);
    check_irq("R2 load wins over tick");

    // R8: divided mode
    set_src(2'd1);
    bus_write(16'hE000, 8'hFE, 0);
    for (int i = 0; i < 15; i++) m2_one();
    check_irq("R8 no tick before 16th pulse");
    m2_one();
    check_irq("R8 tick on 16th pulse");
    bus_write(16'hE000, 8'hFE, 0);
    for (int i = 0; i < 10; i++) m2_one();
    bus_write(16'hE000, 8'hFE, 0);
    for (int i = 0; i < 15; i++) m2_one();
    check_irq("R8 reload restarts prescaler");
    m2_one();
    check_irq("R8 first tick after restart");

    // R9: PPU edge mode
    set_src(2'd2);
    bus_write(16'hE000, 8'hFD, 0);
    for (int i = 0; i < 5; i++) m2_one();
    check_irq("R9 M2 ignored in edge mode");
    ppu_one();
    check_irq("R9 one edge one tick");
    ppu_line = 1'b1;
    repeat (20) @(negedge clk);
    m_cnt = (m_cnt + 1) % 256;
    check_irq("R9 held level counts once");
    ppu_line = 1'b0;
    repeat (20) @(negedge clk);
    check_irq("R9 falling edge ignored");

    // R10: off source
    set_src(2'd3);
    bus_write(16'hE000, 8'hFE, 0);
    for (int i = 0; i < 40; i++) m2_one();
    ppu_one();
    check_irq("R10 no tick when source off");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 4) begin
        set_src(2'($urandom_range(0, 3)));
        bus_write(16'hE000, 8'($urandom_range(240, 255)), 0);
        check_irq("R2 random source change + load");
      end else if (op < 10) begin
        bus_write(16'hE000, ($urandom_range(0, 1) != 0) ? 8'($urandom_range(248, 255))
                                                         : 8'($urandom_range(0, 255)),
                  $urandom_range(0, 1) != 0);
        check_irq("R2 random load");
      end else if (op < 14) begin
        bus_write(16'hE001, 8'($urandom_range(0, 255)), $urandom_range(0, 1) != 0);
        check_irq("R3 random enable write");
      end else if (op < 17) begin
        bus_write(16'($urandom_range(0, 16'hDFFF)), 8'($urandom_range(0, 255)), 0);
        check_irq("R3 random foreign write");
      end else if (op < 22) begin
        ppu_one();
        check_irq("R9 random ppu pulse");
      end else begin
        m2_one();
        check_irq("R4 random m2 pulse");
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule